// File: doc/BRIEF.md
# SMI Power-Change Interrupt Controller

This block raises a system-management interrupt (SMI) whenever software writes one of the power-control registers and that write launches a power-switch sequence toward a socket. The power-switch logic reports each launch as a one-clock pulse per socket. The controller keeps a pending flag for each socket, plus two control bits that every socket shares. One turns SMI generation on. The other picks how the interrupt leaves the block.

Software reaches the control bits through a simple single-cycle register bus. A socket selector picks which socket's copy of the control word a write or read addresses. The shared enable and route bits are the same whichever socket is selected. A pending flag is cleared by writing 1 to it. The interrupt goes out either on the affected socket's card-status-change (CSC) line, or as a single IRQ2 request. On the CSC line a mode input selects level or edge behaviour.

Top module: `smi_pwr_irq`

## Requirements
- R1: After reset the enable, route and both pending flags are 0, `bus_rdata` is 0 and every interrupt output is low.
- R2: A `pwr_seq_start` pulse for a socket while enable is 1 sets that socket's pending flag. The flag reads back at bit 25 of `bus_rdata` for that socket from the next cycle on.
- R3: A `pwr_seq_start` pulse while enable is 0 leaves the pending flag clear, and no interrupt output rises.
- R4: A write with bit 25 set clears the pending flag of the selected socket only. A write with bit 25 clear leaves every pending flag unchanged.
- R5: When a write-1 clear and an enabled event reach the same socket in the same cycle, the flag ends up set.
- R6: Enable (bit 24) and route (bit 26) are shared. Every write loads both from its data. Every socket selector reads back the same values.
- R7: In level mode (`csc_edge_mode`=0) with route 0, `csc_irq[i]` is high exactly while socket i's pending flag is set.
- R8: In edge mode (`csc_edge_mode`=1) with route 0, `csc_irq[i]` is high for the one cycle after socket i's flag goes from 0 to 1. An event while the flag is already set gives no pulse.
- R9: With route 1, `irq2_req` is the OR of the pending flags and every `csc_irq` line is low. With route 0, `irq2_req` is low.
- R10: Every `bus_rdata` bit other than 24, 25 and 26 reads 0. Data in those bits has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the control word |
| bus_sel | input | SEL_W | Socket whose control word is written or read |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Control word of the selected socket (combinational) |
| pwr_seq_start | input | NUM_SOCK | One-clock pulse per socket when a power-switch sequence is launched |
| csc_edge_mode | input | 1 | 0 = level CSC signalling, 1 = edge CSC signalling |
| csc_irq | output | NUM_SOCK | Per-socket card-status-change interrupt |
| irq2_req | output | 1 | IRQ2 request |

## Verification
The assertions assume that `pwr_seq_start` lines are single-cycle pulses that mean nothing while reset is active. They also assume that `bus_sel` names an existing socket whenever `bus_wr` is high. The level-mode property further assumes the mode input is either held or only changed between events. The bench drives every input once per cycle, away from the clock edge. Its random phase picks socket selectors only from the socket range. It lets writes, clears, events and mode changes collide in the same cycle, so that the set-over-clear rule and the shared-bit updates are covered.

// File: rtl/smi_pkg.sv
package smi_pkg;

    // Default bit positions inside the control word
    localparam int SMI_EN_BIT    = 24;
    localparam int SMI_STAT_BIT  = 25;
    localparam int SMI_ROUTE_BIT = 26;

    // Route encoding of the shared route bit
    localparam logic ROUTE_CSC  = 1'b0;
    localparam logic ROUTE_IRQ2 = 1'b1;

    // Shared control state
    typedef struct packed {
        logic en;
        logic route;
    } smi_ctl_t;

    // Per-socket state
    typedef struct packed {
        logic stat;
        logic rise;
    } smi_sock_t;

endpackage

// File: rtl/smi_ctl_regs.sv
module smi_ctl_regs
    import smi_pkg::*;
#(
    parameter int NUM_SOCK  = 2,
    parameter int DATA_W    = 32,
    parameter int SEL_W     = 1,
    parameter int EN_BIT    = SMI_EN_BIT,
    parameter int STAT_BIT  = SMI_STAT_BIT,
    parameter int ROUTE_BIT = SMI_ROUTE_BIT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [NUM_SOCK-1:0] stat_i,
    output logic                en_o,
    output logic                route_o,
    output logic [NUM_SOCK-1:0] clr_o,
    output logic [DATA_W-1:0]   rdata_o
);

    smi_ctl_t ctl_d, ctl_q;

    // Next-state: every write loads both shared bits
    always_comb begin
        ctl_d = ctl_q;
        if (wr_i) begin
            ctl_d.en    = wdata_i[EN_BIT];
            ctl_d.route = wdata_i[ROUTE_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Write-1 clear strobe per socket
    for (genvar g = 0; g < NUM_SOCK; g++) begin : g_clr
        assign clr_o[g] = wr_i && (sel_i == SEL_W'(g)) && wdata_i[STAT_BIT];
    end

    // Read view of the selected socket
    always_comb begin
        rdata_o            = '0;
        rdata_o[EN_BIT]    = ctl_q.en;
        rdata_o[ROUTE_BIT] = ctl_q.route;
        for (int i = 0; i < NUM_SOCK; i++) begin
            if (sel_i == SEL_W'(i)) begin
                rdata_o[STAT_BIT] = stat_i[i];
            end
        end
    end

    assign en_o    = ctl_q.en;
    assign route_o = ctl_q.route;

    AST_SHARED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(ctl_q)); // R6

    AST_SHARED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (en_o == $past(wdata_i[EN_BIT]) && route_o == $past(wdata_i[ROUTE_BIT]))); // R6

    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_o)); // R4

endmodule

// File: rtl/smi_sock_stat.sv
module smi_sock_stat
    import smi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic en_i,
    input  logic clr_i,
    output logic stat_o,
    output logic rise_o
);

    smi_sock_t st_d, st_q;
    logic      set_w;

    assign set_w = evt_i && en_i;

    // Clear first, then set, so a same-cycle event wins
    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.stat = 1'b0;
        end
        if (set_w) begin
            st_d.stat = 1'b1;
        end
        st_d.rise = st_d.stat && !st_q.stat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;
    assign rise_o = st_q.rise;

    AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !stat_o) |=> !stat_o); // R3

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && en_i) |=> stat_o); // R2

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && en_i && clr_i) |=> stat_o); // R5

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(evt_i && en_i)) |=> !stat_o); // R4

    AST_HOLD_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o && !clr_i) |=> stat_o); // R4

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R8

    AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> (stat_o && !$past(stat_o))); // R8

endmodule

// File: rtl/smi_irq_steer.sv
module smi_irq_steer
    import smi_pkg::*;
#(
    parameter int NUM_SOCK = 2
) (
    input  logic                route_i,
    input  logic                edge_mode_i,
    input  logic [NUM_SOCK-1:0] stat_i,
    input  logic [NUM_SOCK-1:0] rise_i,
    output logic [NUM_SOCK-1:0] csc_o,
    output logic                irq2_o
);

    logic to_csc;

    assign to_csc = (route_i == ROUTE_CSC);

    for (genvar g = 0; g < NUM_SOCK; g++) begin : g_csc
        always_comb begin
            csc_o[g] = 1'b0;
            if (to_csc) begin
                csc_o[g] = edge_mode_i ? rise_i[g] : stat_i[g];
            end
        end
    end

    assign irq2_o = (route_i == ROUTE_IRQ2) && (|stat_i);

endmodule

// File: rtl/smi_pwr_irq.sv
module smi_pwr_irq
    import smi_pkg::*;
#(
    parameter int NUM_SOCK  = 2,
    parameter int DATA_W    = 32,
    parameter int SEL_W     = (NUM_SOCK > 1) ? $clog2(NUM_SOCK) : 1,
    parameter int EN_BIT    = SMI_EN_BIT,
    parameter int STAT_BIT  = SMI_STAT_BIT,
    parameter int ROUTE_BIT = SMI_ROUTE_BIT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [SEL_W-1:0]    bus_sel,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_SOCK-1:0] pwr_seq_start,
    input  logic                csc_edge_mode,
    output logic [NUM_SOCK-1:0] csc_irq,
    output logic                irq2_req
);

    logic                en_w;
    logic                route_w;
    logic [NUM_SOCK-1:0] clr_w;
    logic [NUM_SOCK-1:0] stat_w;
    logic [NUM_SOCK-1:0] rise_w;

    smi_ctl_regs #(
        .NUM_SOCK  (NUM_SOCK),
        .DATA_W    (DATA_W),
        .SEL_W     (SEL_W),
        .EN_BIT    (EN_BIT),
        .STAT_BIT  (STAT_BIT),
        .ROUTE_BIT (ROUTE_BIT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr),
        .sel_i   (bus_sel),
        .wdata_i (bus_wdata),
        .stat_i  (stat_w),
        .en_o    (en_w),
        .route_o (route_w),
        .clr_o   (clr_w),
        .rdata_o (bus_rdata)
    );

    for (genvar g = 0; g < NUM_SOCK; g++) begin : g_sock
        smi_sock_stat u_stat (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_i  (pwr_seq_start[g]),
            .en_i   (en_w),
            .clr_i  (clr_w[g]),
            .stat_o (stat_w[g]),
            .rise_o (rise_w[g])
        );

        AST_LEVEL_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_seq_start[g] && en_w && !route_w && !bus_wr && !csc_edge_mode)
            |=> (csc_edge_mode || csc_irq[g])); // R7

        AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_w && !stat_w[g] && !rise_w[g] && !bus_wr) |=> !csc_irq[g]); // R3
    end

    smi_irq_steer #(
        .NUM_SOCK (NUM_SOCK)
    ) u_steer (
        .route_i     (route_w),
        .edge_mode_i (csc_edge_mode),
        .stat_i      (stat_w),
        .rise_i      (rise_w),
        .csc_o       (csc_irq),
        .irq2_o      (irq2_req)
    );

    AST_IRQ2_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata[ROUTE_BIT] |-> !irq2_req); // R9

    AST_CSC_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[ROUTE_BIT] |-> (csc_irq == '0)); // R9

    AST_IRQ2_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (route_w && (stat_w != '0)) |-> irq2_req); // R9

endmodule

// File: tb/sim_smi_pwr_irq.sv
module sim_smi_pwr_irq;

    localparam int NS = 2;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [0:0]    bus_sel = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [NS-1:0] pwr_seq_start = '0;
    logic          csc_edge_mode = 1'b0;
    logic [NS-1:0] csc_irq;
    logic          irq2_req;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_tag = "R1";
    bit    started = 0;
    bit    done = 0;

    // Reference model state
    bit m_en = 0, m_route = 0;
    bit m_stat [NS];
    bit m_pulse [NS];

    always #4 clk = ~clk;

    smi_pwr_irq u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_wr        (bus_wr),
        .bus_sel       (bus_sel),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .pwr_seq_start (pwr_seq_start),
        .csc_edge_mode (csc_edge_mode),
        .csc_irq       (csc_irq),
        .irq2_req      (irq2_req)
    );

    // Model update on the clock edge
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_en = 0; m_route = 0;
            for (int i = 0; i < NS; i++) begin m_stat[i] = 0; m_pulse[i] = 0; end
        end else begin
            for (int i = 0; i < NS; i++) begin
                bit nxt;
                nxt = m_stat[i];
                if (bus_wr && int'(bus_sel) == i && bus_wdata[25]) nxt = 0;
                if (pwr_seq_start[i] && m_en) nxt = 1;
                m_pulse[i] = nxt && !m_stat[i];
                m_stat[i]  = nxt;
            end
            if (bus_wr) begin
                m_en    = bus_wdata[24];
                m_route = bus_wdata[26];
            end
        end
    end

    // Compare every cycle, between the driving edge and the clock edge
    always @(negedge clk) begin
        #2;
        if (started && !done) begin
            logic [DW-1:0] e_rd;
            logic [NS-1:0] e_csc;
            logic          e_irq2;
            e_rd = '0;
            e_rd[24] = m_en;
            e_rd[26] = m_route;
            e_rd[25] = m_stat[int'(bus_sel)];
            e_irq2 = 0;
            for (int i = 0; i < NS; i++) begin
                e_csc[i] = !m_route && (csc_edge_mode ? m_pulse[i] : m_stat[i]);
                if (m_route && m_stat[i]) e_irq2 = 1;
            end
            n_cmp++;
            if (bus_rdata !== e_rd) begin
                n_bad++;
                $display("FAIL %s (R2 R6 R10 rdata) t=%0t actual=%h expected=%h", cur_tag, $time, bus_rdata, e_rd);
            end
            n_cmp++;
            if (csc_irq !== e_csc) begin
                n_bad++;
                $display("FAIL %s (R7 R8 csc) t=%0t actual=%b expected=%b", cur_tag, $time, csc_irq, e_csc);
            end
            n_cmp++;
            if (irq2_req !== e_irq2) begin
                n_bad++;
                $display("FAIL %s (R9 irq2) t=%0t actual=%b expected=%b", cur_tag, $time, irq2_req, e_irq2);
            end
        end
    end

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            bus_wr = 0; pwr_seq_start = '0;
        end
    endtask

    task automatic wr(input int sel, input bit route, input bit clr, input bit en);
        @(negedge clk);
        bus_wr = 1; bus_sel = 1'(sel);
        bus_wdata = '0;
        bus_wdata[26] = route; bus_wdata[25] = clr; bus_wdata[24] = en;
        pwr_seq_start = '0;
    endtask

    task automatic evt(input logic [NS-1:0] v);
        @(negedge clk);
        bus_wr = 0; pwr_seq_start = v;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #400000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_tag = "R1";
        idle(3);
        @(negedge clk); bus_sel = 1;
        idle(1);
        rst_n = 1;
        idle(2);

        // R3: events while disabled
        cur_tag = "R3";
        evt(2'b11); idle(2); evt(2'b01); idle(2);
        @(negedge clk); bus_sel = 0; idle(1);

        // R6: enable through socket 1, read through both
        cur_tag = "R6";
        wr(1, 0, 0, 1); idle(1);
        @(negedge clk); bus_sel = 0; idle(1);

        // R2 / R7: level mode event on socket 0
        cur_tag = "R2 R7";
        csc_edge_mode = 0;
        evt(2'b01); idle(4);
        @(negedge clk); bus_sel = 1; idle(1);

        // R4: write 0 no effect, clear on other socket no effect, then clear
        cur_tag = "R4";
        wr(0, 0, 0, 1); idle(1);
        wr(1, 0, 1, 1); idle(2);
        wr(0, 0, 1, 1); idle(2);

        // R8: edge mode pulse, no repeat while pending
        cur_tag = "R8";
        csc_edge_mode = 1;
        evt(2'b10); idle(2); evt(2'b10); idle(2);
        evt(2'b01); idle(2);

        // R5: clear and event together
        cur_tag = "R5";
        @(negedge clk);
        bus_wr = 1; bus_sel = 1; bus_wdata = 32'h0300_0000; pwr_seq_start = 2'b10;
        idle(2);
        @(negedge clk);
        bus_wr = 1; bus_sel = 0; bus_wdata = 32'h0300_0000; pwr_seq_start = 2'b00;
        idle(1);
        @(negedge clk);
        bus_wr = 1; bus_sel = 0; bus_wdata = 32'h0300_0000; pwr_seq_start = 2'b01;
        idle(2);

        // R9: route to IRQ2
        cur_tag = "R9";
        csc_edge_mode = 0;
        wr(0, 1, 0, 1); idle(2);
        wr(1, 1, 1, 1); idle(1);
        wr(0, 1, 1, 1); idle(2);
        evt(2'b10); idle(3);

        // R10: reserved bits
        cur_tag = "R10";
        @(negedge clk);
        bus_wr = 1; bus_sel = 0; bus_wdata = 32'hF8FF_FFFF; pwr_seq_start = '0;
        idle(2);
        @(negedge clk);
        bus_wr = 1; bus_sel = 1; bus_wdata = 32'hFFFF_FFFF;
        idle(2);

        // Random collisions of writes, clears, events and mode changes
        cur_tag = "R2 R4 R5 R7 R8 R9";
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            bus_sel = 1'($urandom_range(0, 1));
            bus_wr = ($urandom_range(0, 5) == 0);
            bus_wdata = $urandom();
            if ($urandom_range(0, 3) != 0) bus_wdata[24] = 1;
            if ($urandom_range(0, 2) != 0) bus_wdata[26] = 0;
            pwr_seq_start = NS'($urandom_range(0, 3)) & {NS{($urandom_range(0, 2) == 0)}};
            if ($urandom_range(0, 40) == 0) csc_edge_mode = ~csc_edge_mode;
        end
        idle(3);
        finish_run();
    end

endmodule